// File: doc/BRIEF.md
# Flat-Panel Raster Timing Generator

This block drives the raster timing of a 1024x768 flat panel from one pixel clock. It produces an active-low horizontal sync, an active-low vertical sync and an active-high data-enable strobe. It also produces the current column and row counts, which a pixel source uses to fetch the matching pixel. Every line takes the same number of clocks. Every frame takes the same number of lines. Vertical blanking is always a whole number of lines.

The sync width, front porch and back porch of each direction are programmable. A write port puts new values into a staging set of six fields. The staging set is range-checked as a whole. Only a set that passes the check is kept, and it is promoted to the running set on the final clock of a frame. Timing therefore never changes within a frame. A rejected write leaves the staging set as it was and raises a sticky error flag.

The vertical sync is not aligned to a horizontal sync edge. It asserts a fixed number of clocks before the horizontal sync edge of its first line. It releases a programmable distance after the horizontal sync edge of the line that follows its last line. This gives the set-up and hold margins that the panel needs.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is asserted and on the first clock after it, hsync_n=1, vsync_n=1, de=0, hpos=0, vpos=0 and cfg_err=0. Reset loads both the staging set and the running set with the default parameters (full size: sync 136, front 24, back 160 clocks; sync 6, front 3, back 29 lines).
- R2: hpos counts 0 to HT-1 and then wraps, where HT = H_ACTIVE + hsync width + horizontal front porch + horizontal back porch. The line is laid out in this order: active area, front porch, sync, back porch. hsync_n is low for exactly the sync width, starting at hpos = H_ACTIVE + front porch.
- R3: vpos advances by one each time hpos wraps. vpos counts 0 to VT-1 and then wraps, where VT = V_ACTIVE + vsync width + vertical front porch + vertical back porch.
- R4: de is 1 exactly when hpos < H_ACTIVE and vpos < V_ACTIVE.
- R5: vsync_n falls VS_LEAD clocks before the hsync_n falling edge of line V_ACTIVE + vertical front porch.
- R6: vsync_n rises (horizontal back porch + VS_HOLD) clocks after the hsync_n falling edge of line V_ACTIVE + vertical front porch + vsync width.
- R7: A write (wr_en=1) targets one field by wr_addr: 0 hsync width, 1 horizontal front porch, 2 horizontal back porch, 3 vsync width, 4 vertical front porch, 5 vertical back porch. An accepted write stores wr_data in the staging set.
- R8: The staging set is copied to the running set only on the last clock of the last line of a frame. A write during a frame does not change that frame.
- R9: A write that puts a field outside its [MIN, MAX] range is discarded and sets cfg_err. cfg_err then stays 1 until reset.
- R10: A write that leaves the horizontal blanking sum below H_BLANK_MIN, or the vertical blanking sum below V_BLANK_MIN, is discarded and sets cfg_err.
- R11: A write to wr_addr 6 or 7 is discarded and sets cfg_err.
- R12: The outputs are registered. After the n-th clock following reset release, every output reflects raster position n-1, with hpos and vpos counted in the running set in force at that position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Field select for the write |
| wr_data | input | WDATA_W | Value to write |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, active high |
| hpos | output | 12 | Column count within the line |
| vpos | output | 12 | Line count within the frame |
| cfg_err | output | 1 | Sticky rejected-write flag |

## Verification
The bench builds the block with a 16-column, 4-line active area. Its field ranges are scaled down: sync 2..6, front 4..8, back 2..8 clocks; sync 1..3, front 1..2, back 2..4 lines. VS_LEAD and VS_HOLD are both 3, and the blanking minimums are 10 clocks and 5 lines. With these values a frame lasts at most about 500 clocks. A sweep can therefore run dozens of field combinations for whole frames each. The sweep reaches every field limit, both blanking-minimum rejections, and vsync release windows that cross a line boundary. A per-clock arithmetic model checks every output on every clock.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

    localparam int TG_CW     = 12;
    localparam int TG_NFIELD = 6;

    typedef logic [TG_CW-1:0] tg_cnt_t;

    typedef enum logic [2:0] {
        FLD_HSW = 3'd0,
        FLD_HFP = 3'd1,
        FLD_HBP = 3'd2,
        FLD_VSW = 3'd3,
        FLD_VFP = 3'd4,
        FLD_VBP = 3'd5
    } tg_field_e;

    typedef struct packed {
        tg_cnt_t hsw;
        tg_cnt_t hfp;
        tg_cnt_t hbp;
        tg_cnt_t vsw;
        tg_cnt_t vfp;
        tg_cnt_t vbp;
    } tg_cfg_t;

endpackage

// File: rtl/lcd_tg_cfg.sv
module lcd_tg_cfg import lcd_tg_pkg::*; #(
    parameter int WDATA_W     = 8,
    parameter int HSW_MIN     = 4,
    parameter int HSW_MAX     = 136,
    parameter int HSW_DEF     = 136,
    parameter int HFP_MIN     = 4,
    parameter int HFP_MAX     = 24,
    parameter int HFP_DEF     = 24,
    parameter int HBP_MIN     = 24,
    parameter int HBP_MAX     = 160,
    parameter int HBP_DEF     = 160,
    parameter int VSW_MIN     = 2,
    parameter int VSW_MAX     = 6,
    parameter int VSW_DEF     = 6,
    parameter int VFP_MIN     = 1,
    parameter int VFP_MAX     = 3,
    parameter int VFP_DEF     = 3,
    parameter int VBP_MIN     = 2,
    parameter int VBP_MAX     = 29,
    parameter int VBP_DEF     = 29,
    parameter int H_BLANK_MIN = 310,
    parameter int V_BLANK_MIN = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [WDATA_W-1:0] wr_data,
    input  logic               frame_end,
    output tg_cfg_t            act_cfg,
    output logic               cfg_err
);

    localparam int FMIN [TG_NFIELD] = '{HSW_MIN, HFP_MIN, HBP_MIN, VSW_MIN, VFP_MIN, VBP_MIN};
    localparam int FMAX [TG_NFIELD] = '{HSW_MAX, HFP_MAX, HBP_MAX, VSW_MAX, VFP_MAX, VBP_MAX};

    localparam tg_cfg_t CFG_RST = '{
        hsw: tg_cnt_t'(HSW_DEF), hfp: tg_cnt_t'(HFP_DEF), hbp: tg_cnt_t'(HBP_DEF),
        vsw: tg_cnt_t'(VSW_DEF), vfp: tg_cnt_t'(VFP_DEF), vbp: tg_cnt_t'(VBP_DEF)
    };

    typedef struct packed {
        tg_cfg_t shadow;
        tg_cfg_t active;
        logic    err;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    tg_cfg_t                cand;
    tg_cnt_t                wval;
    logic                   addr_ok;
    logic                   blank_ok;
    logic                   wr_ok;
    logic [TG_NFIELD-1:0]   fld_ok;
    tg_cnt_t                cand_f [TG_NFIELD];

    assign wval = tg_cnt_t'(wr_data);

    // Candidate staging set: current staging set with the addressed field replaced.
    always_comb begin
        cand    = st_q.shadow;
        addr_ok = 1'b1;
        case (wr_addr)
            FLD_HSW: cand.hsw = wval;
            FLD_HFP: cand.hfp = wval;
            FLD_HBP: cand.hbp = wval;
            FLD_VSW: cand.vsw = wval;
            FLD_VFP: cand.vfp = wval;
            FLD_VBP: cand.vbp = wval;
            default: addr_ok  = 1'b0;
        endcase
    end

    assign cand_f[0] = cand.hsw;
    assign cand_f[1] = cand.hfp;
    assign cand_f[2] = cand.hbp;
    assign cand_f[3] = cand.vsw;
    assign cand_f[4] = cand.vfp;
    assign cand_f[5] = cand.vbp;

    for (genvar i = 0; i < TG_NFIELD; i++) begin : g_rng
        assign fld_ok[i] = (cand_f[i] >= tg_cnt_t'(FMIN[i])) &&
                           (cand_f[i] <= tg_cnt_t'(FMAX[i]));
    end

    assign blank_ok = ((cand.hsw + cand.hfp + cand.hbp) >= tg_cnt_t'(H_BLANK_MIN)) &&
                      ((cand.vsw + cand.vfp + cand.vbp) >= tg_cnt_t'(V_BLANK_MIN));

    assign wr_ok = addr_ok && (&fld_ok) && blank_ok;

    always_comb begin
        st_d = st_q;
        if (frame_end) begin
            st_d.active = st_q.shadow;
        end
        if (wr_en) begin
            if (wr_ok) begin
                st_d.shadow = cand;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{shadow: CFG_RST, active: CFG_RST, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign act_cfg = st_q.active;
    assign cfg_err = st_q.err;

endmodule

// File: rtl/lcd_tg_counter.sv
module lcd_tg_counter import lcd_tg_pkg::*; #(
    parameter int H_ACTIVE = 1024,
    parameter int V_ACTIVE = 768
) (
    input  logic    clk,
    input  logic    rst_n,
    input  tg_cfg_t cfg,
    output tg_cnt_t h,
    output tg_cnt_t v,
    output logic    frame_end
);

    typedef struct packed {
        tg_cnt_t h;
        tg_cnt_t v;
    } pos_t;

    pos_t    pos_d, pos_q;
    tg_cnt_t h_last, v_last;
    logic    line_end;

    assign h_last    = tg_cnt_t'(H_ACTIVE) + cfg.hsw + cfg.hfp + cfg.hbp - 1'b1;
    assign v_last    = tg_cnt_t'(V_ACTIVE) + cfg.vsw + cfg.vfp + cfg.vbp - 1'b1;
    assign line_end  = (pos_q.h == h_last);
    assign frame_end = line_end && (pos_q.v == v_last);

    always_comb begin
        pos_d = pos_q;
        if (line_end) begin
            pos_d.h = '0;
            pos_d.v = (pos_q.v == v_last) ? '0 : pos_q.v + 1'b1;
        end else begin
            pos_d.h = pos_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign h = pos_q.h;
    assign v = pos_q.v;

endmodule

// File: rtl/lcd_tg_vsync.sv
module lcd_tg_vsync import lcd_tg_pkg::*; #(
    parameter int H_ACTIVE = 1024,
    parameter int V_ACTIVE = 768,
    parameter int VS_LEAD  = 8,
    parameter int VS_HOLD  = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  tg_cnt_t hfp,
    input  tg_cnt_t hbp,
    input  tg_cnt_t vsw,
    input  tg_cnt_t vfp,
    input  tg_cnt_t h,
    input  tg_cnt_t v,
    output logic    vs_act
);

    typedef struct packed {
        logic    act;
        logic    run;
        tg_cnt_t cnt;
    } vs_state_t;

    vs_state_t vs_d, vs_q;
    tg_cnt_t   hs_start, line_on, line_off;

    assign hs_start = tg_cnt_t'(H_ACTIVE) + hfp;
    assign line_on  = tg_cnt_t'(V_ACTIVE) + vfp;
    assign line_off = line_on + vsw;

    // Assert so the flag is set at position hs_start - VS_LEAD of line_on.
    // Release countdown is loaded one clock before the hsync edge of line_off,
    // so the flag clears hbp + VS_HOLD clocks after that edge.
    always_comb begin
        vs_d = vs_q;
        if (!vs_q.act && (v == line_on) &&
            (h == hs_start - tg_cnt_t'(VS_LEAD) - 1'b1)) begin
            vs_d.act = 1'b1;
        end
        if (vs_q.act && !vs_q.run && (v == line_off) && (h == hs_start - 1'b1)) begin
            vs_d.run = 1'b1;
            vs_d.cnt = hbp + tg_cnt_t'(VS_HOLD) - 1'b1;
        end
        if (vs_q.run) begin
            if (vs_q.cnt == '0) begin
                vs_d.act = 1'b0;
                vs_d.run = 1'b0;
            end else begin
                vs_d.cnt = vs_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_q <= '0;
        end else begin
            vs_q <= vs_d;
        end
    end

    assign vs_act = vs_q.act;

endmodule

// File: rtl/lcd_tg_out.sv
module lcd_tg_out import lcd_tg_pkg::*; #(
    parameter int H_ACTIVE = 1024,
    parameter int V_ACTIVE = 768
) (
    input  logic    clk,
    input  logic    rst_n,
    input  tg_cnt_t hsw,
    input  tg_cnt_t hfp,
    input  tg_cnt_t h,
    input  tg_cnt_t v,
    input  logic    vs_act,
    output logic    hsync_n,
    output logic    vsync_n,
    output logic    de,
    output tg_cnt_t hpos,
    output tg_cnt_t vpos
);

    typedef struct packed {
        logic    hs_n;
        logic    vs_n;
        logic    de;
        tg_cnt_t hpos;
        tg_cnt_t vpos;
    } out_t;

    localparam out_t OUT_RST = '{hs_n: 1'b1, vs_n: 1'b1, de: 1'b0, hpos: '0, vpos: '0};

    out_t    o_d, o_q;
    tg_cnt_t hs_start;

    assign hs_start = tg_cnt_t'(H_ACTIVE) + hfp;

    always_comb begin
        o_d.hs_n = !((h >= hs_start) && (h < hs_start + hsw));
        o_d.vs_n = !vs_act;
        o_d.de   = (h < tg_cnt_t'(H_ACTIVE)) && (v < tg_cnt_t'(V_ACTIVE));
        o_d.hpos = h;
        o_d.vpos = v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= OUT_RST;
        end else begin
            o_q <= o_d;
        end
    end

    assign hsync_n = o_q.hs_n;
    assign vsync_n = o_q.vs_n;
    assign de      = o_q.de;
    assign hpos    = o_q.hpos;
    assign vpos    = o_q.vpos;

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen import lcd_tg_pkg::*; #(
    parameter int H_ACTIVE    = 1024,
    parameter int V_ACTIVE    = 768,
    parameter int WDATA_W     = 8,
    parameter int HSW_MIN     = 4,
    parameter int HSW_MAX     = 136,
    parameter int HSW_DEF     = 136,
    parameter int HFP_MIN     = 4,
    parameter int HFP_MAX     = 24,
    parameter int HFP_DEF     = 24,
    parameter int HBP_MIN     = 24,
    parameter int HBP_MAX     = 160,
    parameter int HBP_DEF     = 160,
    parameter int VSW_MIN     = 2,
    parameter int VSW_MAX     = 6,
    parameter int VSW_DEF     = 6,
    parameter int VFP_MIN     = 1,
    parameter int VFP_MAX     = 3,
    parameter int VFP_DEF     = 3,
    parameter int VBP_MIN     = 2,
    parameter int VBP_MAX     = 29,
    parameter int VBP_DEF     = 29,
    parameter int H_BLANK_MIN = 310,
    parameter int V_BLANK_MIN = 10,
    parameter int VS_LEAD     = 8,
    parameter int VS_HOLD     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [WDATA_W-1:0] wr_data,
    output logic               hsync_n,
    output logic               vsync_n,
    output logic               de,
    output logic [TG_CW-1:0]   hpos,
    output logic [TG_CW-1:0]   vpos,
    output logic               cfg_err
);

    tg_cfg_t act_cfg;
    tg_cnt_t h_cnt, v_cnt;
    logic    frame_end;
    logic    vs_act;

    lcd_tg_cfg #(
        .WDATA_W(WDATA_W),
        .HSW_MIN(HSW_MIN), .HSW_MAX(HSW_MAX), .HSW_DEF(HSW_DEF),
        .HFP_MIN(HFP_MIN), .HFP_MAX(HFP_MAX), .HFP_DEF(HFP_DEF),
        .HBP_MIN(HBP_MIN), .HBP_MAX(HBP_MAX), .HBP_DEF(HBP_DEF),
        .VSW_MIN(VSW_MIN), .VSW_MAX(VSW_MAX), .VSW_DEF(VSW_DEF),
        .VFP_MIN(VFP_MIN), .VFP_MAX(VFP_MAX), .VFP_DEF(VFP_DEF),
        .VBP_MIN(VBP_MIN), .VBP_MAX(VBP_MAX), .VBP_DEF(VBP_DEF),
        .H_BLANK_MIN(H_BLANK_MIN), .V_BLANK_MIN(V_BLANK_MIN)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .frame_end(frame_end),
        .act_cfg  (act_cfg),
        .cfg_err  (cfg_err)
    );

    lcd_tg_counter #(.H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (act_cfg),
        .h        (h_cnt),
        .v        (v_cnt),
        .frame_end(frame_end)
    );

    lcd_tg_vsync #(
        .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE),
        .VS_LEAD(VS_LEAD), .VS_HOLD(VS_HOLD)
    ) u_vs (
        .clk   (clk),
        .rst_n (rst_n),
        .hfp   (act_cfg.hfp),
        .hbp   (act_cfg.hbp),
        .vsw   (act_cfg.vsw),
        .vfp   (act_cfg.vfp),
        .h     (h_cnt),
        .v     (v_cnt),
        .vs_act(vs_act)
    );

    lcd_tg_out #(.H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .hsw    (act_cfg.hsw),
        .hfp    (act_cfg.hfp),
        .h      (h_cnt),
        .v      (v_cnt),
        .vs_act (vs_act),
        .hsync_n(hsync_n),
        .vsync_n(vsync_n),
        .de     (de),
        .hpos   (hpos),
        .vpos   (vpos)
    );

endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk import lcd_tg_pkg::*; #(
    parameter int H_ACTIVE = 1024,
    parameter int V_ACTIVE = 768
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic             hsync_n,
    input logic             vsync_n,
    input logic             de,
    input logic [TG_CW-1:0] hpos,
    input logic [TG_CW-1:0] vpos,
    input logic             cfg_err
);

    assert_hpos_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos != '0) |-> (hpos == $past(hpos) + 1'b1));

    assert_vpos_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vpos != $past(vpos)) |-> (hpos == '0));

    assert_de_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> ((hpos < TG_CW'(H_ACTIVE)) && (vpos < TG_CW'(V_ACTIVE))));

    assert_vs_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n) |-> hsync_n);

    assert_vs_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> !de);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    assert_bad_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr > 3'd5)) |=> cfg_err);

endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .hsync_n(hsync_n),
    .vsync_n(vsync_n),
    .de     (de),
    .hpos   (hpos),
    .vpos   (vpos),
    .cfg_err(cfg_err)
);

// File: tb/lcd_timing_gen_test.sv
module lcd_timing_gen_test;
    import lcd_tg_pkg::*;

    localparam int HA = 16, VA = 4;
    localparam int VS_LEAD = 3, VS_HOLD = 3;
    localparam int HBMIN = 10, VBMIN = 5;
    localparam int FMIN [6] = '{2, 4, 2, 1, 1, 2};
    localparam int FMAX [6] = '{6, 8, 8, 3, 2, 4};
    localparam int FDEF [6] = '{4, 5, 6, 2, 1, 3};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [7:0]       wr_data = '0;
    logic             hsync_n, vsync_n, de, cfg_err;
    logic [TG_CW-1:0] hpos, vpos;

    int total = 0, bad = 0, cyc = 0;
    bit done = 1'b0;

    lcd_timing_gen #(
        .H_ACTIVE(HA), .V_ACTIVE(VA), .WDATA_W(8),
        .HSW_MIN(2), .HSW_MAX(6), .HSW_DEF(4),
        .HFP_MIN(4), .HFP_MAX(8), .HFP_DEF(5),
        .HBP_MIN(2), .HBP_MAX(8), .HBP_DEF(6),
        .VSW_MIN(1), .VSW_MAX(3), .VSW_DEF(2),
        .VFP_MIN(1), .VFP_MAX(2), .VFP_DEF(1),
        .VBP_MIN(2), .VBP_MAX(4), .VBP_DEF(3),
        .H_BLANK_MIN(HBMIN), .V_BLANK_MIN(VBMIN),
        .VS_LEAD(VS_LEAD), .VS_HOLD(VS_HOLD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .hpos(hpos), .vpos(vpos),
        .cfg_err(cfg_err)
    );

    always #4ns clk = ~clk;   // 8 ns period, 125 MHz

    // Reference model, advanced on each rising edge from the requirements
    int act [6], sh [6], cand [6];
    int mh, mv, mframes;
    int ht, vt, hs0, lin, vs_s, vs_e;
    bit fe, ok;
    int e_hs_n, e_vs_n, e_de, e_hpos, e_vpos, e_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            act = FDEF; sh = FDEF;
            mh = 0; mv = 0; mframes = 0;
            e_hs_n = 1; e_vs_n = 1; e_de = 0; e_hpos = 0; e_vpos = 0; e_err = 0;
        end else begin
            ht  = HA + act[0] + act[1] + act[2];
            vt  = VA + act[3] + act[4] + act[5];
            hs0 = HA + act[1];
            // R2 R4: line layout and enable window
            e_hs_n = (mh >= hs0 && mh < hs0 + act[0]) ? 0 : 1;
            e_de   = (mh < HA && mv < VA) ? 1 : 0;
            e_hpos = mh;
            e_vpos = mv;
            // R5 R6: vsync window on the frame-linear clock index
            lin  = mv * ht + mh;
            vs_s = (VA + act[4]) * ht + hs0 - VS_LEAD;
            vs_e = (VA + act[4] + act[3]) * ht + hs0 + act[2] + VS_HOLD;
            e_vs_n = (lin >= vs_s && lin < vs_e) ? 0 : 1;
            // R3: advance position
            fe = (mh == ht - 1) && (mv == vt - 1);
            if (mh == ht - 1) begin
                mh = 0;
                mv = (mv == vt - 1) ? 0 : mv + 1;
            end else begin
                mh = mh + 1;
            end
            // R8: promote staging set at frame end
            if (fe) begin
                act = sh;
                mframes = mframes + 1;
            end
            // R7 R9 R10 R11: write acceptance
            if (wr_en) begin
                cand = sh;
                ok = 1'b1;
                if (wr_addr > 3'd5) ok = 1'b0;
                else cand[wr_addr] = int'(wr_data);
                for (int i = 0; i < 6; i++)
                    if (cand[i] < FMIN[i] || cand[i] > FMAX[i]) ok = 1'b0;
                if (cand[0] + cand[1] + cand[2] < HBMIN) ok = 1'b0;
                if (cand[3] + cand[4] + cand[5] < VBMIN) ok = 1'b0;
                if (ok) sh = cand;
                else e_err = 1;
            end
        end
    end

    task automatic chk(input string tag, input string what, input int a, input int e);
        total++;
        if (a != e) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, a, e, $time);
        end
    endtask

    // Compare every output on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk("R1", "hsync_n", int'(hsync_n), e_hs_n);
                chk("R1", "vsync_n", int'(vsync_n), e_vs_n);
                chk("R1", "de", int'(de), e_de);
                chk("R1", "hpos", int'(hpos), e_hpos);
                chk("R1", "vpos", int'(vpos), e_vpos);
                chk("R1", "cfg_err", int'(cfg_err), e_err);
            end else begin
                chk("R2 R12", "hsync_n", int'(hsync_n), e_hs_n);
                chk("R5 R6", "vsync_n", int'(vsync_n), e_vs_n);
                chk("R4", "de", int'(de), e_de);
                chk("R2 R12", "hpos", int'(hpos), e_hpos);
                chk("R3", "vpos", int'(vpos), e_vpos);
                chk("R9 R10 R11", "cfg_err", int'(cfg_err), e_err);
            end
        end
    end

    task automatic finish_up();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
            finish_up();
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        int f0;
        f0 = mframes;
        while (mframes < f0 + n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        #1ns rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1ns rst_n = 1'b1;
    endtask

    initial begin
        int idx;
        // R1: reset state, then default timing
        repeat (3) @(negedge clk);
        #1ns rst_n = 1'b1;
        wait_frames(2);
        // R7 R8: mid-frame writes take effect at the next frame only
        repeat (50) @(negedge clk);
        wr(0, 2); wr(1, 8); wr(2, 2); wr(3, 1); wr(4, 2); wr(5, 2);
        wait_frames(2);
        // R9: out-of-range values; R10: blanking too short; R11: bad addresses
        wr(0, 7); wr(2, 1); wr(1, 4); wr(6, 3); wr(7, 3);
        wait_frames(2);
        // R1: a second reset clears the error and restores the defaults
        do_reset();
        wait_frames(1);
        // Sweep of field combinations, including limits and rejected minimum sums
        idx = 0;
        for (int hs = 2; hs <= 6; hs++)
            for (int hb = 0; hb < 2; hb++)
                for (int vs = 1; vs <= 3; vs++)
                    for (int vb = 0; vb < 2; vb++) begin
                        wr(1, 4 + (idx % 5));
                        wr(0, hs);
                        wr(2, hb ? 8 : 2);
                        wr(3, vs);
                        wr(5, vb ? 4 : 2);
                        wr(4, (idx % 2) + 1);
                        idx++;
                        wait_frames(2);
                    end
        finish_up();
    end

endmodule